// File: doc/BRIEF.md
# Fractional-N Multi-Modulus Divider Controller

This block divides a fast input clock down to one output pulse per main cycle. Inside, a behavioural prescaler divides by 64, 65, 68 or 73. A segment sequencer sets the order of these ratios: first a block of 64-cycles, then optional blocks of 65, 68 and 73, as a two-bit type code selects. The sequencer sizes each block from the counter settings. The main cycle length therefore follows a closed-form sum of the settings.

A small fractional accumulator adds a 3-bit step once per main cycle, modulo 5 or modulo 8. In any main cycle whose add overflows, the last 64-cycle of the first block runs as 65, which lengthens that main cycle by one input clock. The mean ratio is then the integer sum plus step/modulus. The accumulator value is exported for an external compensation path.

New settings are loaded as a pending set. They take effect only at the edge that ends a main cycle, where the 64-block countdown restarts. A running cycle is never disturbed, so reprogramming causes no phase jump. A window flag marks the 64-block countdown.

Top module: `fracn_div_ctrl`

## Requirements
- R1: With `en` held high, the number of input clocks from the clock after one `div_pulse` up to and including the next equals 64*(NM1+2) + 65*NM2 + S68 + S73 (+1 per R4). S68 = 68*(NM3+1) for type codes 2'b10 and 2'b11, else 0. S73 = 73*(NM4+1) for type codes 2'b11 and 2'b00, else 0. Type 2'b01 uses only the 64 and 65 blocks.
- R2: NM2 is taken as all 8 bits of `cfg_nm2` for type codes 2'b01 and 2'b00, and only as `cfg_nm2[3:0]` for type codes 2'b10 and 2'b11.
- R3: At each `div_pulse` edge, `frd` becomes (frd + step) mod Q, where Q = 8 when the mode bit is 1 and Q = 5 when it is 0. In modulo-5 mode a step of 5..7 counts as step-5. The new value is visible from the clock after the pulse.
- R4: A main cycle whose end-of-cycle add overflows (frd + step >= Q, with frd as it stood during that cycle) is exactly one input clock longer than R1's sum.
- R5: A pending set is applied at the first `div_pulse` edge after it was captured. The cycle ending in that pulse still uses the old settings, and the next cycle uses the new ones.
- R6: `load_req` captures the `cfg_*` inputs as the pending set. A later request before application overwrites it. A request in the same cycle as a pulse is held for the following pulse.
- R7: When an applied set changes the modulus bit, `frd` is cleared to 0 at that edge instead of being stepped.
- R8: `sync_win` is high during the first 64*(NM1+2) (+1 when stretched) clocks of each main cycle, and for the whole cycle when type is 2'b01 with NM2 = 0. It is low otherwise.
- R9: While `en` is low, no pulse is issued, `frd` holds, and the position in the main cycle is frozen. Clocks with `en` low do not count toward R1.
- R10: After reset, `div_pulse` = 0, `frd` = 0 and `sync_win` = 1. The settings are type 2'b01 with all counts, step and mode bit 0, so the first main cycle is 128 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock (divider input) |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low freezes the divider |
| load_req | input | 1 | Capture `cfg_*` as the pending set |
| cfg_type | input | 2 | Ratio sequence type code |
| cfg_nm1 | input | 12 | 64-block count minus 2 |
| cfg_nm2 | input | 8 | 65-block count |
| cfg_nm3 | input | 4 | 68-block count minus 1 |
| cfg_nm4 | input | 4 | 73-block count minus 1 |
| cfg_nf | input | 3 | Fractional step per main cycle |
| cfg_mod8 | input | 1 | 1: modulo 8, 0: modulo 5 |
| div_pulse | output | 1 | One-clock pulse on the last clock of each main cycle |
| frd | output | 3 | Fractional accumulator contents |
| sync_win | output | 1 | High while the 64-block countdown runs |

## Verification
The bench tries every type code. The NM2 values chosen make the upper nibble of the 65-block count matter in one type and be ignored in another. An empty 65 block checks that it is skipped. Modulo-5 and modulo-8 steps, including a folded step of 7, drive the accumulator through overflow. Only the stretched cycles reveal a wrong stretch position or the wrong cycle being stretched. Loads are placed mid-cycle, back to back, and in the pulse cycle itself, which separates the application point from overwrite behaviour. Random enable gaps and random settings show whether the cycle position really freezes or merely delays the pulse.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the fractional-N divider controller.
// Assumes the four prescaler ratios are fixed at 64/65/68/73.
package fracn_pkg;
    localparam int RATIO_W = 7;
    localparam int NM1_W   = 12;
    localparam int NM2_W   = 8;
    localparam int NM34_W  = 4;
    localparam int NF_W    = 3;
    localparam int FRD_W   = 3;
    localparam int CNT_W   = NM1_W + 1;

    localparam logic [RATIO_W-1:0] RATIO_A = 7'd64;
    localparam logic [RATIO_W-1:0] RATIO_B = 7'd65;
    localparam logic [RATIO_W-1:0] RATIO_C = 7'd68;
    localparam logic [RATIO_W-1:0] RATIO_D = 7'd73;

    typedef enum logic [1:0] {
        PT_A_D   = 2'b00,
        PT_A_B   = 2'b01,
        PT_A_C   = 2'b10,
        PT_ALL   = 2'b11
    } ptype_e;

    typedef enum logic [1:0] {
        SEG_A = 2'd0,
        SEG_B = 2'd1,
        SEG_C = 2'd2,
        SEG_D = 2'd3
    } seg_e;

    typedef struct packed {
        ptype_e              ptype;
        logic [NM1_W-1:0]    nm1;
        logic [NM2_W-1:0]    nm2;
        logic [NM34_W-1:0]   nm3;
        logic [NM34_W-1:0]   nm4;
        logic [NF_W-1:0]     nf;
        logic                mod8;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{ptype: PT_A_B, nm1: '0, nm2: '0,
                                       nm3: '0, nm4: '0, nf: '0, mod8: 1'b0};

    // Prescaler ratio for a segment.
    function automatic logic [RATIO_W-1:0] seg_ratio(seg_e s);
        case (s)
            SEG_A:   return RATIO_A;
            SEG_B:   return RATIO_B;
            SEG_C:   return RATIO_C;
            default: return RATIO_D;
        endcase
    endfunction
endpackage

// File: rtl/fracn_prescaler.sv
`timescale 1ns/1ps
// Behavioural multi-ratio prescaler: counts input clocks down and ticks
// on the last clock of each prescaler cycle. The ratio of the following
// cycle is sampled on that tick. Assumes ratio_nxt >= 2.
module fracn_prescaler #(
    parameter int RW        = fracn_pkg::RATIO_W,
    parameter int RST_RATIO = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [RW-1:0] ratio_nxt,
    output logic          tick
);
    logic [RW-1:0] pc_q;

    assign tick = en && (pc_q == '0);

    // Down-counter over one prescaler cycle, reloaded on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RW'(RST_RATIO - 1);
        else if (en)
            pc_q <= (pc_q == '0) ? ratio_nxt - 1'b1 : pc_q - 1'b1;
    end
endmodule

// File: rtl/fracn_seq.sv
`timescale 1ns/1ps
// Segment sequencer: walks the 64, 65, 68 and 73 blocks of one main cycle
// in that order, skipping those the type code or an empty 65 count
// leaves out. It stretches the last 64-cycle when asked and flags the
// cycle end. Advances only on prescaler ticks.
module fracn_seq
    import fracn_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  ptype_e             ptype,
    input  logic [NM2_W-1:0]   nm2,
    input  logic [NM34_W-1:0]  nm3,
    input  logic [NM34_W-1:0]  nm4,
    input  logic [NM1_W-1:0]   nm1_new,
    input  logic               stretch,
    output logic [RATIO_W-1:0] ratio_nxt,
    output logic               cycle_end,
    output logic               in_win
);
    seg_e             seg_q, seg_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [NM2_W-1:0] nm2_use;
    logic             has_b, has_c, has_d;
    logic             last_in_seg, to_b, to_c, to_d, wrap;

    // Which blocks exist and where the walk goes after the current block.
    always_comb begin
        nm2_use     = (ptype == PT_A_C || ptype == PT_ALL) ? {4'b0, nm2[3:0]} : nm2;
        has_b       = (nm2_use != '0);
        has_c       = (ptype == PT_A_C || ptype == PT_ALL);
        has_d       = (ptype == PT_ALL || ptype == PT_A_D);
        last_in_seg = (cnt_q == CNT_W'(1));
        to_b        = (seg_q == SEG_A) && has_b;
        to_c        = !to_b && (seg_q == SEG_A || seg_q == SEG_B) && has_c;
        to_d        = !to_b && !to_c && (seg_q != SEG_D) && has_d;
        wrap        = !to_b && !to_c && !to_d;
        cycle_end   = tick && last_in_seg && wrap;
    end

    // Next block, its prescaler-cycle count and the next prescaler ratio.
    always_comb begin
        seg_n     = seg_q;
        cnt_n     = cnt_q - 1'b1;
        ratio_nxt = seg_ratio(seg_q);
        if (!last_in_seg) begin
            if (seg_q == SEG_A && cnt_q == CNT_W'(2) && stretch)
                ratio_nxt = RATIO_B;
        end else begin
            if (to_b) begin
                seg_n = SEG_B;
                cnt_n = CNT_W'(nm2_use);
            end else if (to_c) begin
                seg_n = SEG_C;
                cnt_n = CNT_W'(nm3) + 1'b1;
            end else if (to_d) begin
                seg_n = SEG_D;
                cnt_n = CNT_W'(nm4) + 1'b1;
            end else begin
                seg_n = SEG_A;
                cnt_n = CNT_W'(nm1_new) + CNT_W'(2);
            end
            ratio_nxt = seg_ratio(seg_n);
        end
    end

    // Block state register, moves once per prescaler cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= SEG_A;
            cnt_q <= CNT_W'(2);
        end else if (tick) begin
            seg_q <= seg_n;
            cnt_q <= cnt_n;
        end
    end

    assign in_win = (seg_q == SEG_A);
endmodule

// File: rtl/fracn_accum.sv
`timescale 1ns/1ps
// Fractional accumulator, modulo 5 or 8, stepped once per main cycle.
// Reports whether the pending end-of-cycle add will overflow. Assumes
// the modulus only changes together with a clear.
module fracn_accum
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic             clear,
    input  logic [NF_W-1:0]  nf,
    input  logic             mod8,
    output logic [FRD_W-1:0] frd,
    output logic             stretch
);
    logic [FRD_W-1:0] acc_q;
    logic [NF_W-1:0]  nf_eff;
    logic [FRD_W:0]   sum, q_val;

    // Fold the step into range and form the next sum.
    always_comb begin
        nf_eff  = (!mod8 && nf >= NF_W'(5)) ? nf - NF_W'(5) : nf;
        q_val   = mod8 ? (FRD_W+1)'(8) : (FRD_W+1)'(5);
        sum     = {1'b0, acc_q} + {1'b0, nf_eff};
        stretch = (sum >= q_val);
    end

    // Accumulator register, updated on the cycle-end edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (en && step)
            acc_q <= clear ? '0 : (stretch ? FRD_W'(sum - q_val) : sum[FRD_W-1:0]);
    end

    assign frd = acc_q;
endmodule

// File: rtl/fracn_div_ctrl.sv
`timescale 1ns/1ps
// Fractional-N multi-modulus divider controller (top). Holds the active
// and pending settings and swaps them on the cycle-end edge only. Ties
// prescaler, sequencer and accumulator together. Assumes all inputs are
// synchronous to clk.
module fracn_div_ctrl
    import fracn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load_req,
    input  logic [1:0]        cfg_type,
    input  logic [11:0]       cfg_nm1,
    input  logic [7:0]        cfg_nm2,
    input  logic [3:0]        cfg_nm3,
    input  logic [3:0]        cfg_nm4,
    input  logic [2:0]        cfg_nf,
    input  logic              cfg_mod8,
    output logic              div_pulse,
    output logic [2:0]        frd,
    output logic              sync_win
);
    div_cfg_t             cfg_in, act_q, pend_q;
    logic                 pend_vld_q;
    logic                 tick, cycle_end, apply, clear, stretch, in_win;
    logic [RATIO_W-1:0]   ratio_nxt;
    logic [NM1_W-1:0]     nm1_new;

    // Pack the settings inputs.
    always_comb begin
        cfg_in.ptype = ptype_e'(cfg_type);
        cfg_in.nm1   = cfg_nm1;
        cfg_in.nm2   = cfg_nm2;
        cfg_in.nm3   = cfg_nm3;
        cfg_in.nm4   = cfg_nm4;
        cfg_in.nf    = cfg_nf;
        cfg_in.mod8  = cfg_mod8;
    end

    assign apply   = cycle_end && pend_vld_q;
    assign nm1_new = apply ? pend_q.nm1 : act_q.nm1;
    assign clear   = apply && (pend_q.mod8 != act_q.mod8);

    // Pending set: a new request overwrites, application empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= CFG_RESET;
            pend_vld_q <= 1'b0;
        end else if (load_req) begin
            pend_q     <= cfg_in;
            pend_vld_q <= 1'b1;
        end else if (apply) begin
            pend_vld_q <= 1'b0;
        end
    end

    // Active set: replaced only on the cycle-end edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= CFG_RESET;
        else if (apply)
            act_q <= pend_q;
    end

    fracn_prescaler #(.RW(RATIO_W), .RST_RATIO(64)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ratio_nxt (ratio_nxt),
        .tick      (tick)
    );

    fracn_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ptype     (act_q.ptype),
        .nm2       (act_q.nm2),
        .nm3       (act_q.nm3),
        .nm4       (act_q.nm4),
        .nm1_new   (nm1_new),
        .stretch   (stretch),
        .ratio_nxt (ratio_nxt),
        .cycle_end (cycle_end),
        .in_win    (in_win)
    );

    fracn_accum u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .step    (cycle_end),
        .clear   (clear),
        .nf      (act_q.nf),
        .mod8    (act_q.mod8),
        .frd     (frd),
        .stretch (stretch)
    );

    assign div_pulse = cycle_end;
    assign sync_win  = in_win;
endmodule

// File: rtl/fracn_div_ctrl_chk.sv
`timescale 1ns/1ps
// Assertion checker for fracn_div_ctrl, attached by bind.
module fracn_div_ctrl_chk
    import fracn_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       load_req,
    input logic       div_pulse,
    input logic [2:0] frd,
    input logic       sync_win,
    input div_cfg_t   act_cfg,
    input logic       pend_vld
);
    AST_WIN_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> sync_win);                                        // R8
    AST_FRD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act_cfg.mod8 || (frd < 3'd5));                                  // R3
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse |=> $stable(act_cfg));                               // R5
    AST_HALT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !div_pulse);                                            // R9
    AST_HALT_FRD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(frd));                                          // R9
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld && !div_pulse |=> pend_vld);                           // R6
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> pend_vld);                                         // R6
endmodule

bind fracn_div_ctrl fracn_div_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .load_req  (load_req),
    .div_pulse (div_pulse),
    .frd       (frd),
    .sync_win  (sync_win),
    .act_cfg   (act_q),
    .pend_vld  (pend_vld_q)
);

// File: tb/fracn_div_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: cycle-level reference model of the requirements,
// directed corner cases plus seeded random settings and enable gaps.
module fracn_div_ctrl_tb_top;
    import fracn_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n, en, load_req, cfg_mod8;
    logic [1:0] cfg_type;
    logic [11:0] cfg_nm1;
    logic [7:0] cfg_nm2;
    logic [3:0] cfg_nm3, cfg_nm4;
    logic [2:0] cfg_nf, frd;
    logic       div_pulse, sync_win;

    always #2.5 clk = ~clk;

    fracn_div_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .load_req(load_req),
        .cfg_type(cfg_type), .cfg_nm1(cfg_nm1), .cfg_nm2(cfg_nm2),
        .cfg_nm3(cfg_nm3), .cfg_nm4(cfg_nm4), .cfg_nf(cfg_nf),
        .cfg_mod8(cfg_mod8), .div_pulse(div_pulse), .frd(frd),
        .sync_win(sync_win)
    );

    div_cfg_t m_act, m_pend, hold;
    bit       m_pv;
    int       m_acc, m_k, m_pulses;
    int       n_chk, n_fail, n_cyc;
    string    phase;

    function automatic int nm2u(div_cfg_t c);
        return (c.ptype == PT_A_C || c.ptype == PT_ALL) ? int'(c.nm2[3:0]) : int'(c.nm2);
    endfunction
    function automatic int qv(div_cfg_t c);
        return c.mod8 ? 8 : 5;
    endfunction
    function automatic int nfe(div_cfg_t c);
        return (!c.mod8 && c.nf >= 5) ? int'(c.nf) - 5 : int'(c.nf);
    endfunction
    function automatic int base_n(div_cfg_t c);
        int n;
        n = (int'(c.nm1) + 2) * 64 + nm2u(c) * 65;
        if (c.ptype == PT_A_C || c.ptype == PT_ALL) n += (int'(c.nm3) + 1) * 68;
        if (c.ptype == PT_ALL || c.ptype == PT_A_D) n += (int'(c.nm4) + 1) * 73;
        return n;
    endfunction
    function automatic bit ovf(div_cfg_t c, int a);
        return (a + nfe(c)) >= qv(c);
    endfunction
    function automatic bit single_seg(div_cfg_t c);
        return c.ptype == PT_A_B && nm2u(c) == 0;
    endfunction
    function automatic div_cfg_t mk(logic [1:0] t, int n1, int n2, int n3, int n4,
                                    int f, bit m8);
        div_cfg_t c;
        c.ptype = ptype_e'(t); c.nm1 = 12'(n1); c.nm2 = 8'(n2);
        c.nm3 = 4'(n3); c.nm4 = 4'(n4); c.nf = 3'(f); c.mod8 = m8;
        return c;
    endfunction
    function automatic div_cfg_t rnd_cfg();
        div_cfg_t c;
        c.ptype = ptype_e'($urandom_range(0, 3));
        c.nm1   = 12'($urandom_range(0, 31));
        c.nm2   = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255))
                                              : 8'($urandom_range(0, 15));
        c.nm3   = 4'($urandom_range(0, 15));
        c.nm4   = 4'($urandom_range(0, 15));
        c.nf    = 3'($urandom_range(0, 7));
        c.mod8  = 1'($urandom_range(0, 1));
        return c;
    endfunction

    task automatic chk(bit ok, string req, string what, int a, int e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, phase, what, a, e);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // One clock: drive inputs at the falling edge, check, advance the model.
    task automatic cyc(bit e, bit ld, div_cfg_t c);
        int o, expn, l64;
        bit exp_p, exp_w;
        @(negedge clk);
        en = e; load_req = ld;
        cfg_type = c.ptype; cfg_nm1 = c.nm1; cfg_nm2 = c.nm2; cfg_nm3 = c.nm3;
        cfg_nm4 = c.nm4; cfg_nf = c.nf; cfg_mod8 = c.mod8;
        #1;
        n_cyc++;
        if (n_cyc > 190000) begin
            n_fail++;
            $display("FAIL R1 [%s] watchdog actual=%0d expected=%0d", phase, n_cyc, 190000);
            finish_run();
        end
        o     = int'(ovf(m_act, m_acc));
        expn  = base_n(m_act) + o;
        l64   = (int'(m_act.nm1) + 2) * 64 + o;
        exp_p = e && (m_k + 1 == expn);
        chk(int'(frd) == m_acc, "R3", "frd", int'(frd), m_acc);
        if (e) begin
            exp_w = (m_k < l64) || single_seg(m_act);
            chk(sync_win == exp_w, "R8", "sync_win", int'(sync_win), int'(exp_w));
            chk(div_pulse == exp_p, (o != 0) ? "R1/R4" : "R1", "div_pulse",
                int'(div_pulse), int'(exp_p));
        end else begin
            chk(div_pulse == 1'b0, "R9", "div_pulse while halted", int'(div_pulse), 0);
        end
        if (exp_p) begin
            m_acc = (o != 0) ? m_acc + nfe(m_act) - qv(m_act) : m_acc + nfe(m_act);
            m_k = 0;
            m_pulses++;
            if (m_pv) begin
                if (m_pend.mod8 != m_act.mod8) m_acc = 0;  // R7
                m_act = m_pend;
                m_pv  = 1'b0;
            end
        end else if (e) begin
            m_k++;
        end
        if (ld) begin
            m_pend = c;
            m_pv   = 1'b1;
        end
    endtask

    task automatic run_pulses(int n);
        int start;
        start = m_pulses;
        while (m_pulses < start + n) cyc(1'b1, 1'b0, hold);
    endtask

    task automatic load(div_cfg_t c);
        hold = c;
        cyc(1'b1, 1'b1, c);
    endtask

    // Issue a load in exactly the cycle that carries a pulse.
    task automatic load_at_pulse(div_cfg_t c);
        while (m_k + 1 != base_n(m_act) + int'(ovf(m_act, m_acc))) cyc(1'b1, 1'b0, hold);
        load(c);
    endtask

    initial begin
        void'($urandom(32'd4099));
        n_chk = 0; n_fail = 0; n_cyc = 0; m_pulses = 0;
        m_act = CFG_RESET; m_pend = CFG_RESET; m_pv = 1'b0; m_acc = 0; m_k = 0;
        hold = CFG_RESET;
        rst_n = 1'b0; en = 1'b0; load_req = 1'b0;
        cfg_type = 2'b01; cfg_nm1 = '0; cfg_nm2 = '0; cfg_nm3 = '0; cfg_nm4 = '0;
        cfg_nf = '0; cfg_mod8 = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        phase = "R10 reset state";
        chk(div_pulse == 1'b0, "R10", "div_pulse", int'(div_pulse), 0);
        chk(frd == 3'd0, "R10", "frd", int'(frd), 0);
        chk(sync_win == 1'b1, "R10", "sync_win", int'(sync_win), 1);
        run_pulses(2);                                 // R10: 128-clock cycles

        phase = "R1 type 01 two blocks";
        load(mk(2'b01, 3, 5, 0, 0, 0, 1'b1));
        run_pulses(3);
        phase = "R1 R8 type 01 empty 65 block";
        load(mk(2'b01, 2, 0, 9, 9, 0, 1'b1));
        run_pulses(2);

        phase = "R2 type 10 low nibble only";
        load(mk(2'b10, 1, 8'h3A, 2, 15, 0, 1'b1));
        run_pulses(2);
        phase = "R2 type 00 full 8-bit count";
        load(mk(2'b00, 0, 200, 7, 5, 0, 1'b1));
        run_pulses(2);
        phase = "R2 type 11 low nibble zero";
        load(mk(2'b11, 0, 8'hF0, 3, 4, 0, 1'b1));
        run_pulses(2);

        phase = "R3 R4 modulo 8 step 3";
        load(mk(2'b11, 1, 2, 1, 1, 3, 1'b1));
        run_pulses(10);
        phase = "R7 modulus change clears";
        load(mk(2'b01, 0, 1, 0, 0, 7, 1'b0));
        run_pulses(7);                                 // R3: step 7 folds to 2
        phase = "R7 modulus back to 8";
        load(mk(2'b10, 0, 3, 0, 0, 5, 1'b1));
        run_pulses(4);

        phase = "R5 R6 overwrite before pulse";
        load(mk(2'b01, 5, 1, 0, 0, 1, 1'b1));
        cyc(1'b1, 1'b0, hold);
        load(mk(2'b00, 0, 4, 0, 2, 6, 1'b1));
        run_pulses(3);
        phase = "R6 load in pulse cycle";
        load_at_pulse(mk(2'b11, 2, 1, 1, 0, 4, 1'b0));
        run_pulses(3);

        phase = "R9 enable gaps";
        for (int i = 0; i < 3000; i++) cyc($urandom_range(0, 3) != 0, 1'b0, hold);
        repeat (60) cyc(1'b0, 1'b0, hold);
        run_pulses(2);

        phase = "R1 random settings";
        for (int i = 0; i < 12; i++) begin
            int idle;
            idle = $urandom_range(0, 2000);
            for (int j = 0; j < idle; j++) cyc($urandom_range(0, 15) != 0, 1'b0, hold);
            load(rnd_cfg());
            run_pulses(2);
        end
        finish_run();
    end
endmodule